// File: doc/BRIEF.md
# Compare Output Waveform Unit

This block drives one waveform output from the compare events of a timer. It keeps a one-bit output register and changes it when the counter matches a compare value, or when it reaches the period boundary. A two-bit output-mode field controls the change. What it does with that field depends on the timer's waveform class. In the non-PWM class a match sets, clears or toggles the register. A force strobe applies the same action at once, without a match. In the fast PWM class the register forms a non-inverted or an inverted pulse train, and the force strobe has no effect.

The unit also decides what reaches the pin. If the output-mode field is zero, the pin shows the general-purpose port data bit. If the field is nonzero, the output register takes the place of that bit. The output enable always follows the port's direction bit. Software can therefore preset the register with the force strobe while the pin is still an input, so the first level the pin drives is known.

Top module: `oc_wave_unit`

## Requirements
- R1: Reset clears `oc_reg` to 0.
- R2: With `com_sel` = 00, compare matches and force strobes leave `oc_reg` unchanged, and `pin_val` equals `port_data`.
- R3: With `com_sel` nonzero, `pin_val` equals `oc_reg`. `pin_oe` always equals `port_dir`, whatever the value of `com_sel`.
- R4: The action uses the `com_sel` value present in the cycle of the match or strobe. Writing a new `com_sel` with no event does not change `oc_reg`.
- R5: With `wave_class` = 0 (non-PWM), a match applies an action on the next clock edge: `com_sel` 01 toggles `oc_reg`, 10 clears it and 11 sets it.
- R6: With `wave_class` = 0, `force_stb` applies the action of R5 without a match. If a force and a match fall in the same cycle, the action is applied once.
- R7: With `wave_class` = 1 (fast PWM), `com_sel` 10 clears `oc_reg` on a match and sets it on `at_bottom`. `com_sel` 11 sets it on a match and clears it on `at_bottom`.
- R8: With `wave_class` = 1, `force_stb` has no effect, and `com_sel` 01 leaves `oc_reg` unchanged on every event.
- R9: With `wave_class` = 1, if a match and `at_bottom` fall in the same cycle, the match action takes effect.
- R10: A force in the non-PWM class while `port_dir` = 0 presets `oc_reg` and keeps `pin_oe` low. Once `port_dir` goes to 1, the pin drives the preset level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmp_match | input | 1 | Compare-match pulse |
| at_top | input | 1 | Counter-at-TOP pulse (period edge when PERIOD_AT_TOP=1) |
| at_bottom | input | 1 | Counter-at-BOTTOM pulse (default period edge) |
| wave_class | input | 1 | 0 = non-PWM, 1 = fast PWM |
| com_sel | input | 2 | Output-mode field |
| force_stb | input | 1 | Force strobe |
| port_data | input | 1 | General-purpose port data bit |
| port_dir | input | 1 | Port direction bit, 1 = output |
| oc_reg | output | 1 | Internal output register |
| pin_val | output | 1 | Resolved pin value |
| pin_oe | output | 1 | Pin output enable |

## Verification
Two pairs of events can land in the same cycle. In the non-PWM class, a force strobe can arrive together with a compare match. In fast PWM, a compare match can arrive together with the BOTTOM pulse. The bench drives each pair in a single cycle. It judges the toggle mode by whether `oc_reg` flipped exactly once, and it judges fast PWM by whether the match action won over the BOTTOM action, for both polarities.

// File: rtl/oc_pkg.sv
package oc_pkg;
   typedef enum logic [1:0] {
      ACT_HOLD = 2'd0,
      ACT_CLR  = 2'd1,
      ACT_SET  = 2'd2,
      ACT_TGL  = 2'd3
   } oc_act_e;

   typedef enum logic {
      WAVE_NONPWM = 1'b0,
      WAVE_FAST   = 1'b1
   } wave_e;

   localparam int COM_W = 2;

   function automatic oc_act_e nonpwm_act(input logic [COM_W-1:0] com);
      case (com)
         2'b01:   return ACT_TGL;
         2'b10:   return ACT_CLR;
         2'b11:   return ACT_SET;
         default: return ACT_HOLD;
      endcase
   endfunction
endpackage

// File: rtl/oc_act_decode.sv
module oc_act_decode
   import oc_pkg::*;
#(
   parameter bit PERIOD_AT_TOP = 1'b0,
   parameter bit MATCH_FIRST   = 1'b1
) (
   input  wave_e            wave,
   input  logic [COM_W-1:0] com,
   input  logic             match,
   input  logic             top,
   input  logic             bottom,
   input  logic             force_stb,
   output oc_act_e          act
);
   logic    period_evt;
   oc_act_e np_act;
   oc_act_e m_act;
   oc_act_e e_act;
   oc_act_e pwm_act;

   always_comb begin
      period_evt = PERIOD_AT_TOP ? top : bottom;
      np_act     = (match || force_stb) ? nonpwm_act(com) : ACT_HOLD;
      m_act      = ACT_HOLD;
      e_act      = ACT_HOLD;
      if (com == 2'b10) begin
         m_act = ACT_CLR;
         e_act = ACT_SET;
      end else if (com == 2'b11) begin
         m_act = ACT_SET;
         e_act = ACT_CLR;
      end
   end

   generate
      if (MATCH_FIRST) begin : g_match_first
         always_comb pwm_act = match ? m_act : (period_evt ? e_act : ACT_HOLD);
      end else begin : g_edge_first
         always_comb pwm_act = period_evt ? e_act : (match ? m_act : ACT_HOLD);
      end
   endgenerate

   always_comb act = (wave == WAVE_FAST) ? pwm_act : np_act;
endmodule

// File: rtl/oc_state_reg.sv
module oc_state_reg
   import oc_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  oc_act_e act,
   output logic    oc_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) oc_q <= 1'b0;
      else begin
         case (act)
            ACT_CLR: oc_q <= 1'b0;
            ACT_SET: oc_q <= 1'b1;
            ACT_TGL: oc_q <= ~oc_q;
            default: oc_q <= oc_q;
         endcase
      end
   end

   a_r5_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (act == ACT_SET) |=> oc_q);
   a_r5_clr_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (act == ACT_CLR) |=> !oc_q);
endmodule

// File: rtl/oc_pin_mux.sv
module oc_pin_mux
   import oc_pkg::*;
(
   input  logic [COM_W-1:0] com,
   input  logic             oc_q,
   input  logic             port_data,
   input  logic             port_dir,
   output logic             pin_val,
   output logic             pin_oe
);
   always_comb begin
      pin_val = (com != '0) ? oc_q : port_data;
      pin_oe  = port_dir;
   end
endmodule

// File: rtl/oc_wave_unit.sv
module oc_wave_unit
   import oc_pkg::*;
#(
   parameter bit PERIOD_AT_TOP = 1'b0,
   parameter bit MATCH_FIRST   = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmp_match,
   input  logic       at_top,
   input  logic       at_bottom,
   input  logic       wave_class,
   input  logic [1:0] com_sel,
   input  logic       force_stb,
   input  logic       port_data,
   input  logic       port_dir,
   output logic       oc_reg,
   output logic       pin_val,
   output logic       pin_oe
);
   oc_act_e act;
   wave_e   wave;

   generate
      if (COM_W != 2) begin : g_bad_width
         $error("oc_wave_unit: output-mode field must be 2 bits");
      end
   endgenerate

   assign wave = wave_e'(wave_class);

   oc_act_decode #(
      .PERIOD_AT_TOP (PERIOD_AT_TOP),
      .MATCH_FIRST   (MATCH_FIRST)
   ) u_dec (
      .wave      (wave),
      .com       (com_sel),
      .match     (cmp_match),
      .top       (at_top),
      .bottom    (at_bottom),
      .force_stb (force_stb),
      .act       (act)
   );

   oc_state_reg u_st (
      .clk   (clk),
      .rst_n (rst_n),
      .act   (act),
      .oc_q  (oc_reg)
   );

   oc_pin_mux u_pin (
      .com       (com_sel),
      .oc_q      (oc_reg),
      .port_data (port_data),
      .port_dir  (port_dir),
      .pin_val   (pin_val),
      .pin_oe    (pin_oe)
   );

   a_r1_reset_clear: assert property (@(posedge clk) !rst_n |=> !oc_reg);
   a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (com_sel == 2'b00) |=> $stable(oc_reg));
   a_r5_toggle_flips: assert property (@(posedge clk) disable iff (!rst_n)
      (!wave_class && com_sel == 2'b01 && (cmp_match || force_stb)) |=> (oc_reg != $past(oc_reg)));
   a_r8_force_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (wave_class && force_stb && !cmp_match && !at_bottom && !at_top) |=> $stable(oc_reg));
   a_r3_pin_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (com_sel != 2'b00) |-> (pin_val == oc_reg));
endmodule

// File: tb/oc_wave_unit_tb.sv
module oc_wave_unit_tb;
   localparam time CLK_PERIOD = 10ns;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmp_match = 1'b0, at_top = 1'b0, at_bottom = 1'b0;
   logic wave_class = 1'b0, force_stb = 1'b0;
   logic [1:0] com_sel = 2'b00;
   logic port_data = 1'b0, port_dir = 1'b0;
   logic oc_reg, pin_val, pin_oe;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   oc_wave_unit u_dut (
      .clk(clk), .rst_n(rst_n), .cmp_match(cmp_match), .at_top(at_top),
      .at_bottom(at_bottom), .wave_class(wave_class), .com_sel(com_sel),
      .force_stb(force_stb), .port_data(port_data), .port_dir(port_dir),
      .oc_reg(oc_reg), .pin_val(pin_val), .pin_oe(pin_oe)
   );

   task automatic chk(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%b expected=%b", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic ev(input logic m, input logic b, input logic f);
      cmp_match = m; at_bottom = b; force_stb = f;
      step();
      cmp_match = 1'b0; at_bottom = 1'b0; force_stb = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 reset oc", oc_reg, 1'b0);
      port_data = 1'b1; #1;
      chk("R2 port passthru", pin_val, 1'b1);
   endtask

   task automatic t_nonpwm();
      wave_class = 1'b0; com_sel = 2'b01;
      ev(1, 0, 0); chk("R5 toggle up", oc_reg, 1'b1);
      ev(1, 0, 0); chk("R5 toggle down", oc_reg, 1'b0);
      com_sel = 2'b11; ev(1, 0, 0); chk("R5 set", oc_reg, 1'b1);
      com_sel = 2'b10; ev(1, 0, 0); chk("R5 clear", oc_reg, 1'b0);
   endtask

   task automatic t_com_change();
      com_sel = 2'b11; step();
      chk("R4 no event no change", oc_reg, 1'b0);
      ev(1, 0, 0); chk("R4 new mode on match", oc_reg, 1'b1);
      com_sel = 2'b10; ev(1, 0, 0);
   endtask

   task automatic t_force();
      com_sel = 2'b01;
      ev(0, 0, 1); chk("R6 force toggles", oc_reg, 1'b1);
      ev(1, 0, 1); chk("R6 force+match once", oc_reg, 1'b0);
      com_sel = 2'b11; ev(0, 0, 1); chk("R6 force set", oc_reg, 1'b1);
   endtask

   task automatic t_com00();
      com_sel = 2'b00;
      ev(1, 0, 1); chk("R2 no action", oc_reg, 1'b1);
      port_data = 1'b0; #1;
      chk("R2 pin shows port", pin_val, 1'b0);
   endtask

   task automatic t_pwm();
      wave_class = 1'b1; com_sel = 2'b10;
      ev(1, 0, 0); chk("R7 noninv match clears", oc_reg, 1'b0);
      ev(0, 1, 0); chk("R7 noninv bottom sets", oc_reg, 1'b1);
      com_sel = 2'b11;
      ev(0, 1, 0); chk("R7 inv bottom clears", oc_reg, 1'b0);
      ev(1, 0, 0); chk("R7 inv match sets", oc_reg, 1'b1);
   endtask

   task automatic t_pwm_force();
      com_sel = 2'b10;
      ev(0, 0, 1); chk("R8 force ignored", oc_reg, 1'b1);
      com_sel = 2'b01;
      ev(1, 0, 0); chk("R8 mode01 match", oc_reg, 1'b1);
      ev(0, 1, 0); chk("R8 mode01 bottom", oc_reg, 1'b1);
   endtask

   task automatic t_prio();
      com_sel = 2'b10;
      ev(1, 1, 0); chk("R9 noninv match wins", oc_reg, 1'b0);
      com_sel = 2'b11;
      ev(1, 1, 0); chk("R9 inv match wins", oc_reg, 1'b1);
   endtask

   task automatic t_preset();
      wave_class = 1'b0; com_sel = 2'b10; port_dir = 1'b0;
      ev(0, 0, 1);
      chk("R10 preset level", oc_reg, 1'b0);
      chk("R10 oe low", pin_oe, 1'b0);
      port_dir = 1'b1; port_data = 1'b1; #1;
      chk("R3 oe follows dir", pin_oe, 1'b1);
      chk("R3 pin shows oc", pin_val, 1'b0);
      com_sel = 2'b00; #1;
      chk("R3 released to port", pin_val, 1'b1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      step();
      t_nonpwm();
      t_com_change();
      t_force();
      t_com00();
      t_pwm();
      t_pwm_force();
      t_prio();
      t_preset();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 5000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule